// File: doc/BRIEF.md
# Seconds Prescaler with Start Control and Selectable Clock Output

This block turns a free-running 32.768 kHz oscillator into the one-second heartbeat of a real-time clock. A 15-stage binary divider, whose stages are called F0 (fastest) to F14 (slowest), advances once per oscillator period. Every 0-to-1 transition of F14 produces a one-cycle `sec_tick` pulse in the system clock domain. The same divider also supplies rate enables for a countdown timer and a square-wave clock output. That output has a frequency select and an output enable.

A start control, `stop`, lets software set the time and then start the clock precisely. While `stop` is high, stages F2 to F14 are held at zero and only F0 and F1 keep running. After release, the first second therefore arrives roughly half a second later. Every second after that is a full second. A test mode takes the 64 Hz node away from the internal chain and instead advances F9 to F14 from an external clock pin, so one second takes 64 external edges.

The oscillator level and the external clock are asynchronous. Each passes through its own synchronizer before edge detection. `stop`, `test_mode` and the clock-output controls are expected to come from system-clock registers. Nothing in this block flows as a stream: every pin is a plain level or a single-cycle pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `rtc_prescaler`

## Requirements
- R1: While `stop` is high, stages F2–F14 are held at zero, so `sec_tick` stays low and the 1.024 kHz, 32 Hz and 1 Hz clock outputs stay low. F0 and F1 keep counting, and the 32.768 kHz output keeps toggling.
- R2: In normal mode, the first `sec_tick` after `stop` falls arrives after 16381 to 16384 oscillator rising edges. The spread comes from the free-running F0/F1.
- R3: After the first tick, ticks repeat every 32768 oscillator periods exactly.
- R4: `sec_tick` is high for exactly one system-clock cycle. It rises after the third rising clock edge that follows the oscillator rise which sets F14.
- R5: `clkout_sel` chooses the clock-output source: 00 = synchronized oscillator level (32.768 kHz), 01 = F4 (1.024 kHz), 10 = F9 (32 Hz), 11 = F14 (1 Hz).
- R6: `clkout_oe` is high only when `clkout_en` is 1 and `test_mode` is 0. In test mode the pin acts as an input.
- R7: In test mode, F9–F14 advance only on synchronized rising edges of `ext_clk_in`. The carry out of F8 is ignored, so one tick occurs per 64 external edges.
- R8: In test mode, after `stop` is released, the first tick comes on the 32nd external rising edge.
- R9: `rate_ce` bits are single-cycle enables. Bit 0 pulses on each rise of F2 (4.096 kHz). Bit 1 pulses on each rise of F8 (64 Hz). Bit 2 equals `sec_tick`. Bit 3 pulses on every 60th tick. The 60-tick count is cleared while `stop` is high.
- R10: While `rst_n` is low, all stages and synchronizers are cleared and `sec_tick` and `rate_ce` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | 32.768 kHz oscillator level, asynchronous |
| ext_clk_in | input | 1 | External test clock, asynchronous |
| stop | input | 1 | Hold F2–F14 at zero while high |
| test_mode | input | 1 | External clock drives F9–F14 |
| clkout_en | input | 1 | Clock-output enable |
| clkout_sel | input | 2 | Clock-output frequency select |
| sec_tick | output | 1 | One-cycle one-second pulse |
| clkout | output | 1 | Selected clock-output level |
| clkout_oe | output | 1 | Clock-output drive enable (0 = high impedance) |
| rate_ce | output | 4 | Timer rate enables: 4.096 kHz, 64 Hz, 1 Hz, 1/60 Hz |

## Verification
An oscillator edge needs two synchronizer cycles and one counter update before it reaches the divider. The bench's behavioural model therefore delays its sampled oscillator and external levels by the same three edges. It compares `sec_tick`, `rate_ce`, `clkout` and `clkout_oe` with the model at every falling clock edge. Directed checks measure the first-tick window after `stop` release and the exact 65536-cycle second. For the external-edge counts they wait four cycles after each pulse rises, which leaves room for the three-edge latency, before counting ticks.

// File: rtl/rtc_pre_pkg.sv
`timescale 1ns/1ps
package rtc_pre_pkg;
  typedef enum logic [1:0] {
    SEL_OSC  = 2'b00,
    SEL_KHZ  = 2'b01,
    SEL_32HZ = 2'b10,
    SEL_1HZ  = 2'b11
  } clk_sel_e;

  localparam int RATE_W = 4;
endpackage

// File: rtl/rtc_sync.sv
`timescale 1ns/1ps
module rtc_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [SYNC-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-2:0], d};
  end

  assign q = sh[SYNC-1];
endmodule

// File: rtl/rtc_div_chain.sv
`timescale 1ns/1ps
module rtc_div_chain #(
  parameter int STAGES  = 15,
  parameter int KEEP    = 2,
  parameter int EXT_LSB = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_q,
  input  logic              ext_q,
  input  logic              stop,
  input  logic              test_mode,
  output logic [STAGES-1:0] cnt
);
  localparam int LOW_W = EXT_LSB;
  localparam int UP_W  = STAGES - EXT_LSB;

  logic              osc_last, ext_last;
  logic              adv, ext_adv;
  logic [STAGES-1:0] nxt;
  logic [LOW_W-1:0]  lo;
  logic [UP_W-1:0]   up;

  assign adv     = osc_q & ~osc_last;
  assign ext_adv = ext_q & ~ext_last;

  always_comb begin
    lo  = cnt[LOW_W-1:0];
    up  = cnt[STAGES-1:LOW_W];
    nxt = cnt;
    if (test_mode) begin
      if (adv)     lo = lo + LOW_W'(1);
      if (ext_adv) up = up + UP_W'(1);
      nxt = {up, lo};
    end else if (adv) begin
      nxt = cnt + STAGES'(1);
    end
    if (stop) nxt[STAGES-1:KEEP] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      osc_last <= 1'b0;
      ext_last <= 1'b0;
    end else begin
      cnt      <= nxt;
      osc_last <= osc_q;
      ext_last <= ext_q;
    end
  end
endmodule

// File: rtl/rtc_rate_gen.sv
`timescale 1ns/1ps
module rtc_rate_gen #(
  parameter int STAGES    = 15,
  parameter int TAP_4K    = 2,
  parameter int TAP_64    = 8,
  parameter int MIN_TICKS = 60
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           stop,
  input  logic [STAGES-1:0]              cnt,
  output logic                           tick,
  output logic [rtc_pre_pkg::RATE_W-1:0] rate_ce
);
  localparam int SEC_W = $clog2(MIN_TICKS);
  localparam int NTAP  = 3;
  localparam int TAPS [NTAP] = '{TAP_4K, TAP_64, STAGES-1};

  logic [NTAP-1:0]  rise;
  logic [NTAP-1:0]  prev;
  logic [SEC_W-1:0] sec_cnt;
  logic             wrap;

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[i] <= 1'b0;
      else        prev[i] <= cnt[TAPS[i]];
    end
    assign rise[i] = cnt[TAPS[i]] & ~prev[i];
  end

  assign tick = rise[2];
  assign wrap = tick && (sec_cnt == SEC_W'(MIN_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sec_cnt <= '0;
    else if (stop) sec_cnt <= '0;
    else if (wrap) sec_cnt <= '0;
    else if (tick) sec_cnt <= sec_cnt + SEC_W'(1);
  end

  assign rate_ce = {wrap, rise};
endmodule

// File: rtl/rtc_clkout_mux.sv
`timescale 1ns/1ps
module rtc_clkout_mux #(
  parameter int STAGES  = 15,
  parameter int TAP_1K  = 4,
  parameter int TAP_32  = 9,
  parameter int TAP_1HZ = 14
) (
  input  logic              osc_q,
  input  logic [STAGES-1:0] cnt,
  input  logic [1:0]        sel,
  input  logic              en,
  input  logic              test_mode,
  output logic              clkout,
  output logic              oe
);
  import rtc_pre_pkg::*;

  always_comb begin
    unique case (clk_sel_e'(sel))
      SEL_OSC:  clkout = osc_q;
      SEL_KHZ:  clkout = cnt[TAP_1K];
      SEL_32HZ: clkout = cnt[TAP_32];
      default:  clkout = cnt[TAP_1HZ];
    endcase
  end

  assign oe = en & ~test_mode;
endmodule

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int STAGES    = 15,
  parameter int KEEP      = 2,
  parameter int EXT_W     = 6,
  parameter int SYNC      = 2,
  parameter int MIN_TICKS = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_in,
  input  logic       ext_clk_in,
  input  logic       stop,
  input  logic       test_mode,
  input  logic       clkout_en,
  input  logic [1:0] clkout_sel,
  output logic       sec_tick,
  output logic       clkout,
  output logic       clkout_oe,
  output logic [3:0] rate_ce
);
  localparam int EXT_LSB = STAGES - EXT_W;
  localparam int TAP_1HZ = STAGES - 1;
  localparam int TAP_32  = STAGES - 6;
  localparam int TAP_64  = STAGES - 7;
  localparam int TAP_1K  = STAGES - 11;
  localparam int TAP_4K  = STAGES - 13;

  logic              osc_q, ext_q;
  logic [STAGES-1:0] cnt;

  rtc_sync #(.SYNC(SYNC)) u_osc_sync (
    .clk(clk), .rst_n(rst_n), .d(osc_in), .q(osc_q)
  );

  rtc_sync #(.SYNC(SYNC)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk_in), .q(ext_q)
  );

  rtc_div_chain #(.STAGES(STAGES), .KEEP(KEEP), .EXT_LSB(EXT_LSB)) u_chain (
    .clk(clk), .rst_n(rst_n), .osc_q(osc_q), .ext_q(ext_q),
    .stop(stop), .test_mode(test_mode), .cnt(cnt)
  );

  rtc_rate_gen #(.STAGES(STAGES), .TAP_4K(TAP_4K), .TAP_64(TAP_64),
                 .MIN_TICKS(MIN_TICKS)) u_rate (
    .clk(clk), .rst_n(rst_n), .stop(stop), .cnt(cnt),
    .tick(sec_tick), .rate_ce(rate_ce)
  );

  rtc_clkout_mux #(.STAGES(STAGES), .TAP_1K(TAP_1K), .TAP_32(TAP_32),
                   .TAP_1HZ(TAP_1HZ)) u_mux (
    .osc_q(osc_q), .cnt(cnt), .sel(clkout_sel), .en(clkout_en),
    .test_mode(test_mode), .clkout(clkout), .oe(clkout_oe)
  );
endmodule

// File: rtl/rtc_prescaler_chk.sv
`timescale 1ns/1ps
module rtc_prescaler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop,
  input logic       clkout_en,
  input logic [1:0] clkout_sel,
  input logic       sec_tick,
  input logic       clkout,
  input logic       clkout_oe,
  input logic [3:0] rate_ce
);
  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  // R1
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sec_tick);

  // R1
  stop_divided_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (clkout_sel == 2'b00 || !clkout));

  // R9
  minute_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ce[3] |-> rate_ce[2]);

  // R9
  fast_ce_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_ce[0] |=> !rate_ce[0]);

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clkout_en |-> !clkout_oe);
endmodule

bind rtc_prescaler rtc_prescaler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .clkout_en(clkout_en),
  .clkout_sel(clkout_sel), .sec_tick(sec_tick), .clkout(clkout),
  .clkout_oe(clkout_oe), .rate_ce(rate_ce)
);

// File: tb/rtc_prescaler_test.sv
`timescale 1ns/1ps
module rtc_prescaler_test;
  logic       clk = 1'b0, rst_n = 1'b0, osc_in = 1'b0, ext_clk_in = 1'b0;
  logic       stop = 1'b0, test_mode = 1'b0, clkout_en = 1'b1;
  logic [1:0] clkout_sel = 2'b00;
  logic       sec_tick, clkout, clkout_oe;
  logic [3:0] rate_ce;

  int tests = 0, fails = 0, cyc = 0, n_tick = 0, n_min = 0, n_4k = 0, n_tog = 0;

  rtc_prescaler uut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ext_clk_in(ext_clk_in),
    .stop(stop), .test_mode(test_mode), .clkout_en(clkout_en),
    .clkout_sel(clkout_sel), .sec_tick(sec_tick), .clkout(clkout),
    .clkout_oe(clkout_oe), .rate_ce(rate_ce)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) osc_in <= ~osc_in;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [14:0] m_cnt = '0, m_prev = '0;
  int          m_sec = 0;
  bit          o1, o2, od, e1, e2, ed;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cnt = '0; m_prev = '0; m_sec = 0;
      o1 = 0; o2 = 0; od = 0; e1 = 0; e2 = 0; ed = 0;
    end else begin
      bit advo, adve, tk;
      logic [14:0] oldc;
      int lo, up;
      advo = o2 & ~od;
      adve = e2 & ~ed;
      tk   = m_cnt[14] & ~m_prev[14];
      oldc = m_cnt;
      lo = int'(m_cnt) % 512;
      up = int'(m_cnt) / 512;
      if (test_mode) begin
        if (advo) lo = (lo + 1) % 512;
        if (adve) up = (up + 1) % 64;
        m_cnt = 15'(up * 512 + lo);
      end else if (advo) begin
        m_cnt = 15'((int'(m_cnt) + 1) % 32768);
      end
      if (stop) m_cnt = 15'(int'(m_cnt) % 4);
      if (stop) m_sec = 0;
      else if (tk) m_sec = (m_sec == 59) ? 0 : m_sec + 1;
      m_prev = oldc;
      od = o2; o2 = o1; o1 = osc_in;
      ed = e2; e2 = e1; e1 = ext_clk_in;
    end
    if (cyc > 190000) begin
      chk(0, "watchdog R2", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic       e_tick, e_clk;
      logic [3:0] e_ce;
      e_tick = m_cnt[14] & ~m_prev[14];
      e_ce   = {e_tick && (m_sec == 59), e_tick, m_cnt[8] & ~m_prev[8], m_cnt[2] & ~m_prev[2]};
      case (clkout_sel)
        2'b00:   e_clk = o2;
        2'b01:   e_clk = m_cnt[4];
        2'b10:   e_clk = m_cnt[9];
        default: e_clk = m_cnt[14];
      endcase
      chk(sec_tick == e_tick, "model R4 tick", sec_tick, e_tick);
      chk(rate_ce == e_ce, "model R9 rate_ce", rate_ce, e_ce);
      chk(clkout == e_clk, "model R5 clkout", clkout, e_clk);
      chk(clkout_oe == (clkout_en & ~test_mode), "model R6 oe", clkout_oe, clkout_en & ~test_mode);
      if (sec_tick) n_tick++;
      if (rate_ce[3]) n_min++;
      if (rate_ce[0]) n_4k++;
    end
  end

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ext_clk_in = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    int t0, t1, base, bmin;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(sec_tick == 0, "R10 tick in reset", sec_tick, 0);
    chk(rate_ce == 0, "R10 rate_ce in reset", rate_ce, 0);
    chk(clkout == 0, "R10 clkout in reset", clkout, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R6 output enable
    clkout_en = 1'b0; @(negedge clk);
    chk(clkout_oe == 0, "R6 en=0", clkout_oe, 0);
    clkout_en = 1'b1; @(negedge clk);
    chk(clkout_oe == 1, "R6 en=1", clkout_oe, 1);
    test_mode = 1'b1; @(negedge clk);
    chk(clkout_oe == 0, "R6 test mode", clkout_oe, 0);
    test_mode = 1'b0;

    // R1 stop holds divided outputs, 32k keeps running
    stop = 1'b1; clkout_sel = 2'b01;
    repeat (20) @(negedge clk);
    base = n_tick; n_tog = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (clkout) n_tog++;
    end
    chk(n_tog == 0, "R1 1k output held", n_tog, 0);
    chk(n_tick == base, "R1 no tick in stop", n_tick - base, 0);
    clkout_sel = 2'b00; n_tog = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clkout) n_tog++;
    end
    chk(n_tog >= 18 && n_tog <= 22, "R1 R5 32k runs in stop", n_tog, 20);

    // R2 first tick window, R3 full second
    clkout_sel = 2'b11;
    @(negedge clk) stop = 1'b0;
    t0 = cyc; base = n_tick;
    while (n_tick == base) @(negedge clk);
    t1 = cyc;
    chk((t1 - t0) >= 32760 && (t1 - t0) <= 32775, "R2 first tick", t1 - t0, 32768);
    chk(clkout == 1, "R5 1Hz high after tick", clkout, 1);
    base = n_tick; t0 = t1;
    while (n_tick == base) @(negedge clk);
    t1 = cyc;
    chk((t1 - t0) == 65536, "R3 second period", t1 - t0, 65536);

    // R9 4.096 kHz enable rate: one per 8 oscillator periods
    base = n_4k;
    repeat (1600) @(negedge clk);
    chk((n_4k - base) >= 99 && (n_4k - base) <= 101, "R9 4k rate", n_4k - base, 100);

    // R8, R7 test mode
    test_mode = 1'b1; stop = 1'b1;
    repeat (10) @(negedge clk);
    stop = 1'b0;
    repeat (5) @(negedge clk);
    base = n_tick;
    ext_pulses(31);
    chk(n_tick == base, "R8 no tick before 32 edges", n_tick - base, 0);
    ext_pulses(1);
    chk(n_tick == base + 1, "R8 tick on 32nd edge", n_tick - base, 1);
    ext_pulses(63);
    chk(n_tick == base + 1, "R7 no tick before 64 edges", n_tick - base, 1);
    ext_pulses(1);
    chk(n_tick == base + 2, "R7 tick on 64th edge", n_tick - base, 2);

    // R9 minute enable after 60 ticks from stop release
    stop = 1'b1;
    repeat (10) @(negedge clk);
    stop = 1'b0;
    repeat (5) @(negedge clk);
    base = n_tick; bmin = n_min;
    ext_pulses(32 + 58 * 64);
    chk(n_tick == base + 59, "R9 59 ticks", n_tick - base, 59);
    chk(n_min == bmin, "R9 no minute yet", n_min - bmin, 0);
    ext_pulses(64);
    chk(n_min == bmin + 1, "R9 minute pulse", n_min - bmin, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule